// File: doc/BRIEF.md
# Sparse Parallel-Prefix Adder

This block adds two unsigned N-bit operands and a carry-in with no clock and no state, and returns the N-bit sum and the carry-out. The design has two levels. First, each operand bit pair is turned into a generate/propagate pair. Each group of bits is then folded into one group pair.

A logarithmic-depth prefix tree combines the group pairs. It yields only the carries that enter each group boundary, plus the final carry-out. A short ripple chain inside each group then uses its boundary carry as carry-in and works out the sum bits of that group.

Both the width and the group size are parameters, with defaults of 16 and 4. The width must be a whole number of groups; any other setting stops elaboration. The tree is sparse because it carries one column per group instead of one column per bit. This keeps its node count and wiring low, while the depth stays logarithmic in the group count.

Top module: `skadd_top`

## Requirements
- R1: For every input combination, the concatenation {cout, sum} equals A + B + cin as an (N+1)-bit unsigned value.
- R2: With both operands zero, the sum equals cin in bit 0 and zero elsewhere, and cout is 0.
- R3: The carry entering each group boundary, at bit positions GROUP, 2·GROUP and so on, equals the carry out of the sum of all lower bits with cin. A carry produced in a lower group is therefore seen in the next group's lowest sum bit.
- R4: When A and B are bitwise complements, every bit propagates. Then cout equals cin, and the sum is all ones when cin is 0 and all zeros when cin is 1.
- R5: With both operands all ones, cout is 1 and the sum is all ones with bit 0 equal to cin.
- R6: A carry produced in the low bits of a group ripples to the higher bits of the same group. For example, 0x0007 + 0x0001 gives 0x0008.
- R7: With A all ones, B zero and cin 1, the carry passes through every group: the sum is zero and cout is 1.
- R8: The same function holds for other legal parameter settings, in particular N = 8 (every input combination) and N = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | WIDTH | First operand, unsigned |
| b    | input     | WIDTH | Second operand, unsigned |
| cin  | input     | 1     | Carry into bit 0 |
| sum  | output    | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output    | 1     | Carry out of the most significant bit |

## Verification
The bench goes after the carry paths that a sparse tree can get wrong.

- **Boundary carries.** A design that took a boundary carry from the wrong tree column, or left out the carry-in term, shows a wrong lowest sum bit in a group.
- **Full-propagate patterns.** Operands that are bitwise complements need cin to travel the whole width. A tree with too few levels, or a wrong propagate merge, would drop cout or leave stale ones in the sum.
- **Ripple inside a group.** Carries that stay inside one group find a broken ripple chain.
- **Other widths.** Exhaustive 8-bit operands and random 32-bit operands show faults in the level count, such as a tree that only works at the default width.

// File: rtl/skadd_pkg.sv
package skadd_pkg;

   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // hi covers the more significant span, lo the adjacent lower span
   function automatic gp_t gp_merge(gp_t hi, gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

endpackage

// File: rtl/skadd_gp_gen.sv
module skadd_gp_gen #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] g,
   output logic [WIDTH-1:0] p
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign g[i] = a[i] & b[i];
      assign p[i] = a[i] ^ b[i];
   end

endmodule

// File: rtl/skadd_prefix_tree.sv
module skadd_prefix_tree
   import skadd_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0]       g,
   input  logic [WIDTH-1:0]       p,
   input  logic                   cin,
   // carry[m] enters bit m*GROUP; carry[NGRP] is the final carry-out
   output logic [WIDTH/GROUP:0]   carry
);

   localparam int NGRP   = WIDTH / GROUP;
   localparam int NODES  = NGRP + 1;
   localparam int LEVELS = (NODES > 1) ? $clog2(NODES) : 1;

   gp_t grp [NGRP];
   gp_t nd  [NODES];
   gp_t nx  [NODES];

   // fold each group of bits into a single generate/propagate pair
   for (genvar gi = 0; gi < NGRP; gi++) begin : g_fold
      gp_t acc;
      always_comb begin
         acc.g = g[gi*GROUP];
         acc.p = p[gi*GROUP];
         for (int i = 1; i < GROUP; i++) begin
            acc = gp_merge('{g: g[gi*GROUP+i], p: p[gi*GROUP+i]}, acc);
         end
         grp[gi] = acc;
      end
   end

   // node 0 carries cin as the generate of a virtual bit below bit 0
   always_comb begin
      nd[0] = '{g: cin, p: 1'b0};
      for (int m = 0; m < NGRP; m++) begin
         nd[m+1] = grp[m];
      end
      for (int k = 0; k < LEVELS; k++) begin
         for (int j = 0; j < NODES; j++) begin
            if (j >= (1 << k)) begin
               nx[j] = gp_merge(nd[j], nd[j - (1 << k)]);
            end else begin
               nx[j] = nd[j];
            end
         end
         for (int j = 0; j < NODES; j++) begin
            nd[j] = nx[j];
         end
      end
      for (int j = 0; j < NODES; j++) begin
         carry[j] = nd[j].g;
      end
   end

endmodule

// File: rtl/skadd_rca_group.sv
module skadd_rca_group #(
   parameter int GROUP = 4
) (
   input  logic [GROUP-1:0] g,
   input  logic [GROUP-1:0] p,
   input  logic             ci,
   output logic [GROUP-1:0] s,
   output logic             co
);

   logic [GROUP:0] c;

   assign c[0] = ci;

   for (genvar i = 0; i < GROUP; i++) begin : g_fa
      assign s[i]   = p[i] ^ c[i];
      assign c[i+1] = g[i] | (p[i] & c[i]);
   end

   assign co = c[GROUP];

endmodule

// File: rtl/skadd_top.sv
module skadd_top #(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int NGRP = WIDTH / GROUP;

   if (GROUP < 1) begin : g_bad_group
      $error("skadd_top: GROUP must be at least 1");
   end
   if (WIDTH < GROUP) begin : g_bad_width
      $error("skadd_top: WIDTH must be at least GROUP");
   end
   if ((WIDTH % GROUP) != 0) begin : g_bad_mult
      $error("skadd_top: WIDTH must be a multiple of GROUP");
   end

   logic [WIDTH-1:0] bit_g;
   logic [WIDTH-1:0] bit_p;
   logic [NGRP:0]    grp_cin;
   logic [NGRP-1:0]  grp_cout;

   skadd_gp_gen #(.WIDTH(WIDTH)) u_gp (
      .a (a),
      .b (b),
      .g (bit_g),
      .p (bit_p)
   );

   skadd_prefix_tree #(.WIDTH(WIDTH), .GROUP(GROUP)) u_tree (
      .g     (bit_g),
      .p     (bit_p),
      .cin   (cin),
      .carry (grp_cin)
   );

   for (genvar m = 0; m < NGRP; m++) begin : g_grp
      skadd_rca_group #(.GROUP(GROUP)) u_rca (
         .g  (bit_g[m*GROUP +: GROUP]),
         .p  (bit_p[m*GROUP +: GROUP]),
         .ci (grp_cin[m]),
         .s  (sum[m*GROUP +: GROUP]),
         .co (grp_cout[m])
      );
   end

   assign cout = grp_cin[NGRP];

endmodule

// File: rtl/skadd_chk.sv
module skadd_chk #(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input logic [WIDTH-1:0]       a,
   input logic [WIDTH-1:0]       b,
   input logic                   cin,
   input logic [WIDTH-1:0]       sum,
   input logic                   cout,
   input logic [WIDTH/GROUP:0]   tree_c,
   input logic [WIDTH/GROUP-1:0] rca_co
);

   localparam int NGRP = WIDTH / GROUP;

   function automatic logic low_carry(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                      logic ci, int nbits);
      logic [WIDTH:0] mask;
      logic [WIDTH:0] t;
      mask = ({{WIDTH{1'b0}}, 1'b1} << nbits) - 1'b1;
      t = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {{WIDTH{1'b0}}, ci};
      return t[nbits];
   endfunction

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         assert_sum_exact_R1 : assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("R1: sum/cout mismatch");
         if (a == '0 && b == '0) begin
            assert_cin_only_R2 : assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout)
               else $error("R2: zero operands");
         end
         assert_tree_base_R3 : assert (tree_c[0] == cin)
            else $error("R3: carry into group 0");
         for (int m = 1; m <= NGRP; m++) begin
            assert_boundary_carry_R3 : assert (tree_c[m] == low_carry(a, b, cin, m*GROUP))
               else $error("R3: boundary carry %0d", m);
         end
         for (int m = 0; m < NGRP; m++) begin
            assert_ripple_meets_tree_R6 : assert (rca_co[m] == tree_c[m+1])
               else $error("R6: group %0d ripple carry differs from tree", m);
         end
         if ((a ^ b) == '1) begin
            assert_full_prop_R4 : assert (cout == cin && sum == {WIDTH{~cin}})
               else $error("R4: full propagate");
         end
         if (a == '1 && b == '1) begin
            assert_max_ops_R5 : assert (cout && sum == {{(WIDTH-1){1'b1}}, cin})
               else $error("R5: max operands");
         end
         if (a == '1 && b == '0 && cin) begin
            assert_chain_R7 : assert (cout && sum == '0)
               else $error("R7: full chain");
         end
      end
   end

endmodule

bind skadd_top skadd_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
   .a      (a),
   .b      (b),
   .cin    (cin),
   .sum    (sum),
   .cout   (cout),
   .tree_c (grp_cin),
   .rca_co (grp_cout)
);

// File: tb/skadd_top_tb.sv
`timescale 1ns/1ps
module skadd_top_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [15:0] a16, b16, s16;
   logic        c16, co16;
   logic [7:0]  a8, b8, s8;
   logic        c8, co8;
   logic [31:0] a32, b32, s32;
   logic        c32, co32;

   skadd_top u_dut (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
   skadd_top #(.WIDTH(8),  .GROUP(4)) u_dut8  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
   skadd_top #(.WIDTH(32), .GROUP(4)) u_dut32 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [32:0] expq[$];

   task automatic chk(string tag, logic [32:0] got, logic [32:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic drive16(logic [15:0] x, logic [15:0] y, logic ci, string tag);
      longint unsigned e;
      @(posedge clk);
      a16 = x; b16 = y; c16 = ci;
      e = longint'(x) + longint'(y) + longint'(ci);
      expq.push_back(e[32:0]);
      @(negedge clk);
      chk(tag, {16'd0, co16, s16}, expq.pop_front());
   endtask

   initial begin
      a16 = '0; b16 = '0; c16 = 1'b0;
      a8  = '0; b8  = '0; c8  = 1'b0;
      a32 = '0; b32 = '0; c32 = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 idle zero", {16'd0, co16, s16}, 33'd0);
      rst_n = 1'b1;

      drive16(16'h0000, 16'h0000, 1'b1, "R2 cin only");
      drive16(16'h000F, 16'h0001, 1'b0, "R3 carry into bit4");
      drive16(16'h00F0, 16'h0010, 1'b0, "R3 carry into bit8");
      drive16(16'h0FFF, 16'h0000, 1'b1, "R3 carry into bit12");
      drive16(16'hA5C3, 16'h5A3C, 1'b0, "R4 complement cin0");
      drive16(16'h1234, 16'hEDCB, 1'b1, "R4 complement cin1");
      drive16(16'hFFFF, 16'hFFFF, 1'b1, "R5 max cin1");
      drive16(16'hFFFF, 16'hFFFF, 1'b0, "R5 max cin0");
      drive16(16'h0007, 16'h0001, 1'b0, "R6 in-group ripple");
      drive16(16'h0300, 16'h0100, 1'b1, "R6 in-group ripple upper");
      drive16(16'hFFFF, 16'h0000, 1'b1, "R7 full chain");
      drive16(16'h8000, 16'h8000, 1'b0, "R1 top-bit carry");

      for (int v = 0; v < 131072; v++) begin
         longint unsigned e8, e16, e32;
         logic [31:0] r1, r2;
         @(posedge clk);
         a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
         a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
         r1 = $urandom; r2 = $urandom;
         a32 = r1; b32 = r2; c32 = 1'($urandom);
         e8  = longint'(a8)  + longint'(b8)  + longint'(c8);
         e16 = longint'(a16) + longint'(b16) + longint'(c16);
         e32 = longint'(a32) + longint'(b32) + longint'(c32);
         @(negedge clk);
         chk("R8 exhaustive width 8", {24'd0, co8, s8}, e8[32:0]);
         chk("R1 random width 16", {16'd0, co16, s16}, e16[32:0]);
         chk("R8 random width 32", {co32, s32}, e32[32:0]);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual unfinished expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule